// File: doc/BRIEF.md
# Core Clock Rate Controller

This block turns a fixed master clock into the processor core's working rate. A power-of-two divide ratio is held in an 8-bit control register. The output is a single-cycle clock-enable pulse, `core_ce`, and not a gated clock, so every downstream register stays on the master clock and the design remains synthesizable. The same register holds an oscillator power-down control, which is driven straight out on a pin. It also shows the lock state of an external frequency loop, which is read-only.

An optional fast-service mode runs interrupt handlers at the undivided rate. A small state machine follows interrupt entry and return pulses, keeping a nesting depth. It has three states. `ST_IDLE` means no interrupt is being serviced. `ST_FAST` means the service runs at full speed. `ST_SLOW` means the service runs at the programmed rate. The transitions are:
- `enter_fast`: `ST_IDLE` to `ST_FAST`, on entry with the fast bit set.
- `enter_slow`: `ST_IDLE` to `ST_SLOW`, on entry with the fast bit clear.
- `leave_outer`: `ST_FAST` or `ST_SLOW` to `ST_IDLE`, when the outermost handler returns.
- `nest`: any service state to itself, on an inner entry or return.

A new divide ratio, whether it was written or forced by the override, is adopted only at a division-period boundary. This means no enable pulse ever comes early or late.

Top module: `core_rate_ctrl`

## Requirements
- R1: After reset, a read at address 0xD7 returns 0x53 when `pll_locked` is 1. The enable then pulses once every 8 master cycles, which is divider code 3.
- R2: Divider code N in bits 2..0 gives exactly one `core_ce` pulse per 2^N master cycles in steady state, for N = 0 to 7.
- R3: A new divider code is adopted at the end of the current period. The period in progress when the write lands keeps its old length, and the next period uses the new length.
- R4: When bit 3 (fast enable) is 1 at the outermost interrupt entry, `core_ce` is high on every cycle once the current period ends.
- R5: Nested entries are counted. Full speed is kept until the return that matches the outermost entry.
- R6: When bit 3 is 0 at the outermost entry, the rate is unchanged during the service.
- R7: Bit 6 reads the `pll_locked` input, and writes to bit 6 have no effect.
- R8: Bits 5..4 always read 01, and writes to them have no effect.
- R9: Bit 7 is written by software and appears on `osc_pd`. Its reset value is 0.
- R10: A write at any address other than 0xD7 changes nothing. A read at any other address returns 0x00.
- R11: After the outermost return, the programmed divider rate resumes at the next period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Full-byte write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: the register at 0xD7, else zero |
| irq_enter | input | 1 | One-cycle pulse when an interrupt handler starts |
| irq_return | input | 1 | One-cycle pulse when a handler returns |
| pll_locked | input | 1 | Lock status from the external loop |
| core_ce | output | 1 | Single-cycle core clock enable |
| osc_pd | output | 1 | Oscillator power-down control |

## Verification
The assertions assume that `irq_enter` and `irq_return` are single-cycle pulses. They also assume that a return never arrives without a matching entry and that nesting stays below the depth limit. The bench issues entries and returns one at a time, a few cycles apart, and keeps its nesting to two levels. Register writes are one-cycle strobes that the bench drives on the falling edge. The depth counter and the boundary latch therefore see each event exactly once.

// File: rtl/core_rate_pkg.sv
package core_rate_pkg;
    localparam int CODE_W = 3;
    localparam logic [7:0] REG_ADDR  = 8'hD7;
    localparam logic [7:0] RESET_VAL = 8'h53;
    localparam int BIT_PD   = 7;
    localparam int BIT_LOCK = 6;
    localparam int BIT_FAST = 3;
    localparam logic [1:0] RSVD_VAL = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FAST = 2'd1,
        ST_SLOW = 2'd2
    } svc_state_t;
endpackage

// File: rtl/core_rate_regs.sv
module core_rate_regs
    import core_rate_pkg::*;
#(
    parameter logic [7:0] ADDR = REG_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        addr,
    input  logic              wr,
    input  logic [7:0]        wdata,
    input  logic              lock_in,
    output logic [7:0]        rdata,
    output logic              pd_bit,
    output logic              fast_bit,
    output logic [CODE_W-1:0] code
);
    logic hit;
    assign hit = (addr == ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_bit   <= RESET_VAL[BIT_PD];
            fast_bit <= RESET_VAL[BIT_FAST];
            code     <= RESET_VAL[CODE_W-1:0];
        end else if (wr && hit) begin
            pd_bit   <= wdata[BIT_PD];
            fast_bit <= wdata[BIT_FAST];
            code     <= wdata[CODE_W-1:0];
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (hit) begin
            rdata[BIT_PD]       = pd_bit;
            rdata[BIT_LOCK]     = lock_in;
            rdata[5:4]          = RSVD_VAL;
            rdata[BIT_FAST]     = fast_bit;
            rdata[CODE_W-1:0]   = code;
        end
    end

    assert_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> rdata[5:4] == RSVD_VAL);
    assert_pd_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit) |=> pd_bit == $past(wdata[BIT_PD]));
    assert_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !hit) |=> $stable(code) && $stable(fast_bit) && $stable(pd_bit));
endmodule

// File: rtl/core_rate_svc.sv
module core_rate_svc
    import core_rate_pkg::*;
#(
    parameter int DEPTH_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    input  logic leave,
    input  logic fast_en,
    output logic override
);
    localparam logic [DEPTH_W-1:0] DEPTH_MAX = '1;

    svc_state_t        state_q, state_d;
    logic [DEPTH_W-1:0] depth_q, depth_d;
    logic up, down;

    assign up   = enter && !leave && (depth_q != DEPTH_MAX);
    assign down = leave && !enter && (depth_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            depth_q <= '0;
        end else begin
            state_q <= state_d;
            depth_q <= depth_d;
        end
    end

    always_comb begin
        state_d = state_q;
        depth_d = depth_q;
        if (up)   depth_d = depth_q + 1'b1;
        if (down) depth_d = depth_q - 1'b1;
        unique case (state_q)
            ST_IDLE: if (enter && !leave) state_d = fast_en ? ST_FAST : ST_SLOW;
            ST_FAST,
            ST_SLOW: if (down && depth_q == DEPTH_W'(1)) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        override = (state_q == ST_FAST);
    end

    assert_idle_depth_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> depth_q == '0);
    assert_stray_return_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && leave && !enter) |=> state_q == ST_IDLE);
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_q == DEPTH_MAX && enter && !leave) |=> depth_q == DEPTH_MAX);
endmodule

// File: rtl/core_rate_gen.sv
module core_rate_gen
    import core_rate_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] sel_code,
    output logic          ce
);
    localparam int CNT_W = (1 << CW) - 1;
    localparam logic [CW-1:0] RST_CODE = RESET_VAL[CW-1:0];

    logic [CW-1:0]    cur_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;
    logic             last;

    assign span = (CNT_W+1)'(1) << cur_q;
    assign last = ({1'b0, cnt_q} == span - 1'b1);
    assign ce   = last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cur_q <= RST_CODE;
        end else if (last) begin
            cnt_q <= '0;
            cur_q <= sel_code;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_boundary_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ce) |-> $stable(cur_q));
    assert_full_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && sel_code == '0) |=> ce);
endmodule

// File: rtl/core_rate_ctrl.sv
module core_rate_ctrl
    import core_rate_pkg::*;
#(
    parameter logic [7:0] ADDR    = REG_ADDR,
    parameter int         DEPTH_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       irq_enter,
    input  logic       irq_return,
    input  logic       pll_locked,
    output logic       core_ce,
    output logic       osc_pd
);
    logic              fast_en;
    logic              override;
    logic [CODE_W-1:0] prog_code;
    logic [CODE_W-1:0] eff_code;

    core_rate_regs #(.ADDR(ADDR)) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
        .wdata(bus_wdata), .lock_in(pll_locked), .rdata(bus_rdata),
        .pd_bit(osc_pd), .fast_bit(fast_en), .code(prog_code)
    );

    core_rate_svc #(.DEPTH_W(DEPTH_W)) svc_i (
        .clk(clk), .rst_n(rst_n), .enter(irq_enter), .leave(irq_return),
        .fast_en(fast_en), .override(override)
    );

    assign eff_code = override ? '0 : prog_code;

    core_rate_gen #(.CW(CODE_W)) gen_i (
        .clk(clk), .rst_n(rst_n), .sel_code(eff_code), .ce(core_ce)
    );

    assert_lock_view_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR) |-> bus_rdata[BIT_LOCK] == pll_locked);
endmodule

// File: tb/core_rate_ctrl_tb.sv
module core_rate_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_enter = 1'b0;
    logic       irq_return = 1'b0;
    logic       pll_locked = 1'b1;
    logic       core_ce;
    logic       osc_pd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    core_rate_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_enter(irq_enter),
        .irq_return(irq_return), .pll_locked(pll_locked), .core_ce(core_ce),
        .osc_pd(osc_pd)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = 8'h00;
    endtask

    task automatic count_ce(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (core_ce) c++;
        end
    endtask

    task automatic pulse_enter();
        @(negedge clk); irq_enter = 1'b1;
        @(negedge clk); irq_enter = 1'b0;
    endtask

    task automatic pulse_return();
        @(negedge clk); irq_return = 1'b1;
        @(negedge clk); irq_return = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d; int c;
        rd_reg(8'hD7, d);
        check("R1 reset value", d, 8'h53);
        check("R9 osc_pd reset", osc_pd, 0);
        count_ce(512, c);
        check("R1 default rate", c, 64);
    endtask

    task automatic t_rates();
        int c;
        for (int n = 0; n < 8; n++) begin
            wr_reg(8'hD7, 8'(n));
            idle(300);
            count_ce(512, c);
            check($sformatf("R2 code %0d", n), c, 512 >> n);
        end
    endtask

    task automatic t_boundary();
        int gap;
        wr_reg(8'hD7, 8'h03);
        idle(300);
        while (!core_ce) @(negedge clk);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
            if (gap == 2) begin bus_addr = 8'hD7; bus_wdata = 8'h00; bus_wr = 1'b1; end
            if (gap == 3) begin bus_wr = 1'b0; bus_addr = 8'h00; end
        end while (!core_ce);
        check("R3 old period kept", gap, 8);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!core_ce);
        check("R3 new period used", gap, 1);
    endtask

    task automatic t_fast_nest();
        int c;
        wr_reg(8'hD7, 8'h0F);
        idle(300);
        pulse_enter();
        idle(140);
        count_ce(64, c);
        check("R4 full speed in handler", c, 64);
        pulse_enter();
        idle(5);
        pulse_return();
        idle(140);
        count_ce(64, c);
        check("R5 held after inner return", c, 64);
        pulse_return();
        idle(140);
        count_ce(1024, c);
        check("R11 programmed rate resumes", c, 8);
    endtask

    task automatic t_slow_irq();
        int c;
        wr_reg(8'hD7, 8'h02);
        idle(300);
        pulse_enter();
        idle(10);
        count_ce(64, c);
        check("R6 rate unchanged", c, 16);
        pulse_return();
        idle(20);
    endtask

    task automatic t_fields();
        logic [7:0] d;
        wr_reg(8'hD7, 8'hFF);
        rd_reg(8'hD7, d);
        check("R8 R7 full write readback", d, 8'hDF);
        check("R9 osc_pd driven", osc_pd, 1);
        wr_reg(8'hD7, 8'h00);
        rd_reg(8'hD7, d);
        check("R7 R8 zero write readback", d, 8'h50);
        check("R9 osc_pd cleared", osc_pd, 0);
        pll_locked = 1'b0;
        rd_reg(8'hD7, d);
        check("R7 lock follows input", d, 8'h10);
        pll_locked = 1'b1;
        wr_reg(8'hD6, 8'hAF);
        rd_reg(8'hD7, d);
        check("R10 miss write ignored", d, 8'h50);
        check("R10 miss write osc_pd", osc_pd, 0);
        rd_reg(8'hD6, d);
        check("R10 miss read zero", d, 8'h00);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        t_reset();
        t_rates();
        t_boundary();
        t_fast_nest();
        t_slow_irq();
        t_fields();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule